// File: doc/BRIEF.md
# Timer Compare Match Unit

This block sits beside a free-running or period-limited timer counter and watches the counter value against a programmable compare register. When the two are equal it emits a registered match indication for a downstream waveform generator. It also latches a compare flag that raises an interrupt request when that interrupt is enabled. The flag is not set in the match cycle itself. It is set on the first timer-clock tick that follows the match. A tick is a one-cycle enable pulse supplied by a prescaler.

The flag can be cleared in two ways: by a write-one strobe from software, or by an acknowledge from the interrupt controller once the request has been serviced. A control input selects whether the compare register also acts as the counter's period limit. The block drives the active limit value back to the counter and reports, as registered strobes, when the counter sits at that limit and when it sits at zero.

Top module: `tocmp_top`

## Requirements
- R1: While `rst` is high at a clock edge, `match_o`, `top_o`, `bottom_o`, `flag_o` and `irq_o` become 0, `top_val_o` becomes all ones, and the compare register becomes 0.
- R2: `match_o` is 1 in the cycle after an edge at which `cnt_val` equals the compare register, and 0 otherwise, whatever the state of `tick_en`.
- R3: A value presented on `cmp_wdata` with `cmp_we` high is stored at that edge. Comparisons at that same edge still use the previous value, and comparisons at later edges use the new one.
- R4: The flag is set at the first edge with `tick_en` high that comes strictly after the edge at which `match_o` rose. Until such a tick arrives, the flag does not set. Several matches before one tick produce a single set.
- R5: After each edge, `irq_o` equals the new flag value ANDed with `irq_en` sampled at that edge.
- R6: An edge with `irq_ack` high and no flag set event clears the flag.
- R7: An edge with `flag_wr1` high and no flag set event clears the flag.
- R8: When a flag set event and a clear (`flag_wr1` or `irq_ack`) occur at the same edge, the flag ends up set.
- R9: With `top_sel` high at an edge, `top_val_o` takes the compare register value, and `top_o` is 1 if `cnt_val` equalled the compare register. With `top_sel` low, `top_val_o` becomes all ones, and `top_o` is 1 only if `cnt_val` was all ones.
- R10: `bottom_o` is 1 in the cycle after an edge at which `cnt_val` was zero, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle timer clock enable from the prescaler |
| cnt_val | input | 16 | Current timer counter value |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 16 | Compare register write data |
| top_sel | input | 1 | 1: compare register is the counter limit; 0: limit is all ones |
| irq_en | input | 1 | Compare interrupt enable |
| flag_wr1 | input | 1 | Software write-one-to-clear strobe for the flag |
| irq_ack | input | 1 | Interrupt serviced acknowledge, clears the flag |
| match_o | output | 1 | Registered equality strobe for the waveform generator |
| top_o | output | 1 | Registered strobe: counter at the active limit |
| bottom_o | output | 1 | Registered strobe: counter at zero |
| top_val_o | output | 16 | Active counter limit value |
| flag_o | output | 1 | Compare flag |
| irq_o | output | 1 | Compare interrupt request |

## Verification
A wrong compare register value appears on `match_o` and on `top_val_o` one cycle after the counter passes the intended value, so the bench steps the counter directly onto and beside that value. The pending-match state cannot be seen directly. If it is lost or duplicated, `flag_o` rises early, rises late or never rises on the tick after a match. The bench therefore places ticks both in the match cycle and several cycles later. Errors in clear priority show on `flag_o` and `irq_o` in the cycle right after a set event and a clear collide.

// File: rtl/tocmp_pkg.sv
package tocmp_pkg;
  // Registered comparator strobes handed to the waveform generator.
  typedef struct packed {
    logic match;
    logic top;
    logic bottom;
  } cmp_evt_t;

  localparam int unsigned TOCMP_DEF_W = 16;
endpackage

// File: rtl/tocmp_cmpreg.sv
module tocmp_cmpreg #(
  parameter int unsigned W           = 16,
  parameter bit          TOP_FROM_CMP = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         top_sel,
  output logic [W-1:0] cmp_q,
  output logic [W-1:0] top_cmb,
  output logic [W-1:0] top_val_q
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)        cmp_q <= '0;
    else if (wr_en) cmp_q <= wr_data;
  end

  generate
    if (TOP_FROM_CMP) begin : g_sel_top
      assign top_cmb = top_sel ? cmp_q : ALL_ONES;
    end else begin : g_fixed_top
      assign top_cmb = ALL_ONES;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) top_val_q <= ALL_ONES;
    else     top_val_q <= top_cmb;
  end

  // R9: a fixed limit is selected whenever the mode input is low.
  a_r9_fixed_limit: assert property (@(posedge clk) disable iff (rst)
    !top_sel |=> (top_val_q == ALL_ONES));
endmodule

// File: rtl/tocmp_compare.sv
module tocmp_compare
  import tocmp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_q,
  input  logic [W-1:0] top_cmb,
  output cmp_evt_t     evt_q
);
  cmp_evt_t evt_d;

  always_comb begin
    evt_d.match  = (cnt == cmp_q);
    evt_d.top    = (cnt == top_cmb);
    evt_d.bottom = (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) evt_q <= '0;
    else     evt_q <= evt_d;
  end

  // R10: a zero strobe always refers to a zero count one cycle earlier.
  a_r10_bottom_zero: assert property (@(posedge clk) disable iff (rst)
    evt_q.bottom |-> ($past(cnt) == '0));
endmodule

// File: rtl/tocmp_flag.sv
module tocmp_flag (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic match_q,
  input  logic wr1_clr,
  input  logic ack,
  input  logic irq_en,
  output logic flag_q,
  output logic irq_q
);
  logic pend_q;
  logic armed;
  logic set_evt;
  logic clr_evt;
  logic flag_d;

  always_comb begin
    armed   = pend_q | match_q;
    set_evt = tick_en & armed;
    clr_evt = wr1_clr | ack;
    if (set_evt)      flag_d = 1'b1;
    else if (clr_evt) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= armed & ~tick_en;
      flag_q <= flag_d;
      irq_q  <= flag_d & irq_en;
    end
  end

  // R4: the flag only rises on a timer tick.
  a_r4_set_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(tick_en));
  // R6: acknowledge without a tick leaves the flag clear.
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack && !tick_en) |=> !flag_q);
  // R8: a pending match meeting a tick sets the flag whatever clears arrive.
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (tick_en && (pend_q || match_q)) |=> flag_q);
  // R5: no request without the flag.
  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q);
endmodule

// File: rtl/tocmp_top.sv
module tocmp_top
  import tocmp_pkg::*;
#(
  parameter int unsigned W            = TOCMP_DEF_W,
  parameter bit          TOP_FROM_CMP = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic [W-1:0] cnt_val,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  input  logic         top_sel,
  input  logic         irq_en,
  input  logic         flag_wr1,
  input  logic         irq_ack,
  output logic         match_o,
  output logic         top_o,
  output logic         bottom_o,
  output logic [W-1:0] top_val_o,
  output logic         flag_o,
  output logic         irq_o
);
  logic [W-1:0] cmp_q;
  logic [W-1:0] top_cmb;
  cmp_evt_t     evt_q;

  tocmp_cmpreg #(.W(W), .TOP_FROM_CMP(TOP_FROM_CMP)) u_cmpreg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cmp_we),
    .wr_data   (cmp_wdata),
    .top_sel   (top_sel),
    .cmp_q     (cmp_q),
    .top_cmb   (top_cmb),
    .top_val_q (top_val_o)
  );

  tocmp_compare #(.W(W)) u_compare (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt_val),
    .cmp_q   (cmp_q),
    .top_cmb (top_cmb),
    .evt_q   (evt_q)
  );

  tocmp_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .match_q (evt_q.match),
    .wr1_clr (flag_wr1),
    .ack     (irq_ack),
    .irq_en  (irq_en),
    .flag_q  (flag_o),
    .irq_q   (irq_o)
  );

  assign match_o  = evt_q.match;
  assign top_o    = evt_q.top;
  assign bottom_o = evt_q.bottom;

  // R4: a match strobe never sets the flag in its own cycle without a tick.
  a_r4_no_early_flag: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && !tick_en) |=> !flag_o);
  // R7: a write-one clear without a tick empties the flag.
  a_r7_wr1_clears: assert property (@(posedge clk) disable iff (rst)
    (flag_wr1 && !tick_en) |=> !flag_o);
endmodule

// File: tb/tocmp_top_tb_top.sv
module tocmp_top_tb_top;
  localparam int unsigned W = 16;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  typedef struct {
    logic         match;
    logic         top;
    logic         bottom;
    logic [W-1:0] topval;
    logic         flag;
    logic         irq;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic [W-1:0] cnt_val = '0;
  logic cmp_we = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic top_sel = 1'b0;
  logic irq_en = 1'b0;
  logic flag_wr1 = 1'b0;
  logic irq_ack = 1'b0;
  logic match_o, top_o, bottom_o, flag_o, irq_o;
  logic [W-1:0] top_val_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  exp_t sb[$];

  // bench model state
  logic [W-1:0] m_cmp = '0;
  logic m_match = 0, m_top = 0, m_bot = 0, m_pend = 0, m_flag = 0, m_irq = 0;
  logic [W-1:0] m_topval = ONES;

  always #10 clk = ~clk;

  tocmp_top dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_val(cnt_val),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .top_sel(top_sel),
    .irq_en(irq_en), .flag_wr1(flag_wr1), .irq_ack(irq_ack),
    .match_o(match_o), .top_o(top_o), .bottom_o(bottom_o),
    .top_val_o(top_val_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic step(input logic r, input logic tk, input logic [W-1:0] c,
                      input logic we, input logic [W-1:0] wd, input logic ts,
                      input logic ie, input logic w1, input logic ak,
                      input string tag);
    exp_t e;
    logic armed, setv, fl;
    @(negedge clk);
    rst = r; tick_en = tk; cnt_val = c; cmp_we = we; cmp_wdata = wd;
    top_sel = ts; irq_en = ie; flag_wr1 = w1; irq_ack = ak;
    if (r) begin
      m_cmp = '0; m_match = 0; m_top = 0; m_bot = 0; m_pend = 0;
      m_flag = 0; m_irq = 0; m_topval = ONES;
    end else begin
      armed = m_pend | m_match;
      setv  = tk & armed;
      fl    = setv ? 1'b1 : ((w1 | ak) ? 1'b0 : m_flag);
      m_pend   = armed & ~tk;
      m_flag   = fl;
      m_irq    = fl & ie;
      m_match  = (c == m_cmp);
      m_top    = (c == (ts ? m_cmp : ONES));
      m_bot    = (c == '0);
      m_topval = ts ? m_cmp : ONES;
      if (we) m_cmp = wd;
    end
    e.match = m_match; e.top = m_top; e.bottom = m_bot; e.topval = m_topval;
    e.flag = m_flag; e.irq = m_irq; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // monitor: compare after each edge, away from both edges
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "match_o",   {15'd0, match_o},  {15'd0, e.match});
        chk(e.tag, "top_o",     {15'd0, top_o},    {15'd0, e.top});
        chk(e.tag, "bottom_o",  {15'd0, bottom_o}, {15'd0, e.bottom});
        chk(e.tag, "top_val_o", top_val_o,         e.topval);
        chk(e.tag, "flag_o",    {15'd0, flag_o},   {15'd0, e.flag});
        chk(e.tag, "irq_o",     {15'd0, irq_o},    {15'd0, e.irq});
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // args: rst tick cnt we wdata tsel ien wr1 ack tag
    step(1, 0, 16'h0003, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 1, 16'h0000, 0, 0, 0, 0, 0, 0, "R1");
    // R10 zero count, R2 reset compare value 0 matches count 0
    step(0, 0, 16'h0000, 0, 0, 0, 1, 0, 0, "R10");
    step(0, 0, 16'h0001, 0, 0, 0, 1, 0, 1, "R10");
    // R3 write 5 while count is 5: old value used this edge
    step(0, 0, 16'h0005, 1, 16'h0005, 0, 1, 0, 1, "R3");
    step(0, 0, 16'h0005, 0, 0, 0, 1, 0, 1, "R3");
    // R4 no tick yet: flag waits; second match before tick
    step(0, 0, 16'h0006, 0, 0, 0, 1, 0, 0, "R4");
    step(0, 0, 16'h0005, 0, 0, 0, 1, 0, 0, "R4");
    step(0, 1, 16'h0007, 0, 0, 0, 1, 0, 0, "R4");
    step(0, 1, 16'h0008, 0, 0, 0, 1, 0, 0, "R4");
    // R6 acknowledge clears
    step(0, 0, 16'h0009, 0, 0, 0, 1, 0, 1, "R6");
    // tick in the same cycle as the match edge must not set (R4)
    step(0, 1, 16'h0005, 0, 0, 0, 1, 0, 0, "R4");
    step(0, 0, 16'h0006, 0, 0, 0, 1, 0, 0, "R4");
    step(0, 1, 16'h0006, 0, 0, 0, 1, 0, 0, "R4");
    // R7 write-one clear
    step(0, 0, 16'h0006, 0, 0, 0, 1, 1, 0, "R7");
    // R8 set and clear collide
    step(0, 0, 16'h0005, 0, 0, 0, 1, 0, 0, "R8");
    step(0, 1, 16'h0002, 0, 0, 0, 1, 1, 1, "R8");
    // R5 enable off masks the request, flag stays
    step(0, 0, 16'h0002, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 16'h0002, 0, 0, 0, 1, 0, 0, "R5");
    step(0, 0, 16'h0002, 0, 0, 0, 0, 1, 0, "R5");
    // R9 limit from compare register
    step(0, 0, 16'h0005, 0, 0, 1, 0, 0, 0, "R9");
    step(0, 0, 16'hFFFF, 0, 0, 1, 0, 0, 0, "R9");
    step(0, 0, 16'hFFFF, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 16'h0005, 0, 0, 0, 0, 0, 1, "R9");
    // R3 new limit value after write, R9 limit follows
    step(0, 0, 16'h1234, 1, 16'h1234, 1, 0, 0, 1, "R3");
    step(0, 0, 16'h1234, 0, 0, 1, 0, 0, 1, "R3");
    step(0, 0, 16'h0000, 0, 0, 1, 0, 0, 1, "R2");
    // R1 reset mid-run clears flag and compare register
    step(0, 1, 16'h0001, 0, 0, 1, 1, 0, 0, "R2");
    step(1, 0, 16'h0001, 0, 0, 1, 1, 0, 0, "R1");
    step(0, 0, 16'h0000, 0, 0, 1, 1, 0, 0, "R1");
    step(0, 0, 16'h0007, 0, 0, 0, 0, 0, 0, "R1");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule